// File: doc/BRIEF.md
# Packed Fixed-Point Tanh Unit

This block is a functional unit that sits beside a small processor core and evaluates the hyperbolic tangent as a single operation. The core hands it one 32-bit register word and gets one 32-bit word back. A mode input decides how the word is split. In one mode it holds two signed 16-bit neuron sums. In the other it holds four signed 8-bit sums. Every lane is evaluated in parallel in the same cycle.

Each lane takes the magnitude of its input and keeps the sign aside. The odd symmetry of tanh means only non-negative arguments need a table. A range decoder sorts the magnitude into one of three bands. Below 1.0 a finely spaced table segment is used. From 1.0 up to 3.0 a more widely spaced segment is used. At 3.0 and above the lane returns the largest code below 1.0. Where a segment's spacing is wider than one input step, the two neighbouring entries are blended linearly. The table contents are computed at elaboration from real-valued tanh. The sign is applied again on the way out.

A request is a one-cycle `start` pulse. The registered result appears with `done` in the next cycle. A request that arrives during that `done` cycle is dropped.

Top module: `packed_tanh_unit`

## Requirements
- R1: With `lane_mode`=0, `operand[15:0]` and `operand[31:16]` are each a signed Q3.12 value. The matching `result` fields are signed Q1.14. For every input with magnitude below 3.0, each result lies within 2 LSB of tanh of the input.
- R2: With `lane_mode`=1, `operand[8k+7:8k]` for k=0..3 are signed Q2.5 values. The matching `result` fields are signed Q1.6. For every input with magnitude below 3.0, each result lies within 2 LSB of tanh of the input.
- R3: An input with magnitude 3.0 or above gives exactly the saturation code, or its negation when the input is negative. The saturation code is 16383 (0x3FFF, negated 0xC001) in 16-bit lanes and 63 (0x3F, negated 0xC1) in 8-bit lanes.
- R4: The most negative lane input, 0x8000 or 0x80, gives the negated saturation code.
- R5: The result for -x is the exact two's-complement negation of the result for x. A non-negative input never gives a negative result.
- R6: Each lane's result depends only on its own input field.
- R7: `done` is high for exactly the one cycle after a cycle in which `start` was sampled high while `done` was low. No `done` appears otherwise.
- R8: `start` sampled while `done` is high is ignored. No `done` follows it, and `result` keeps its value.
- R9: Between accepted requests, `result` holds its value whatever `operand` and `lane_mode` do.
- R10: While reset is high and after it is released, before any request, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse |
| lane_mode | input | 1 | 0: two 16-bit lanes, 1: four 8-bit lanes |
| operand | input | 32 | Packed signed lane inputs |
| done | output | 1 | Result valid, one cycle after an accepted request |
| result | output | 32 | Packed signed tanh results, held until the next request |

## Verification
Two situations are hard to reach from the ports. The first is a request that lands in the same cycle as `done`. It only arises when `start` is held across two edges, so the bench keeps `start` high for a second cycle and swaps in a different operand. It then confirms that no second `done` follows and that `result` still shows the first operand. The second is the seams between bands and the single most negative code, which only a few input values touch. The bench therefore sweeps every 16-bit and every 8-bit input code, placing x and -x in paired lanes. The odd-symmetry property is then checked exactly on every code, alongside the tolerance against real tanh.

// File: rtl/tanh_pkg.sv
package tanh_pkg;
  typedef enum logic [1:0] {
    BAND_FINE   = 2'd0,
    BAND_COARSE = 2'd1,
    BAND_SAT    = 2'd2
  } tanh_band_e;

  typedef enum logic {
    PACK_2X16 = 1'b0,
    PACK_4X8  = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/tanh_range_dec.sv
module tanh_range_dec
  import tanh_pkg::*;
#(
  parameter int MAG_W  = 15,
  parameter int IN_FRAC = 12
) (
  input  logic [MAG_W-1:0]   mag,
  output tanh_band_e         band,
  output logic [IN_FRAC-1:0] fine_off,
  output logic [IN_FRAC:0]   coarse_off
);
  localparam logic [MAG_W-1:0] ONE_CODE   = MAG_W'(1) << IN_FRAC;
  localparam logic [MAG_W-1:0] THREE_CODE = MAG_W'(3) << IN_FRAC;
  localparam logic [IN_FRAC:0] OFF_ONE    = (IN_FRAC+1)'(1) << IN_FRAC;

  always_comb begin
    if (mag < ONE_CODE)        band = BAND_FINE;
    else if (mag < THREE_CODE) band = BAND_COARSE;
    else                       band = BAND_SAT;
  end

  // distance from the band start; coarse band spans two units, so IN_FRAC+1 bits
  assign fine_off   = mag[IN_FRAC-1:0];
  assign coarse_off = mag[IN_FRAC:0] - OFF_ONE;
endmodule

// File: rtl/tanh_segment.sv
module tanh_segment #(
  parameter int OFF_W    = 12,
  parameter int IN_FRAC  = 12,
  parameter int OUT_FRAC = 14,
  parameter int STEP_SH  = 5,
  parameter int BASE     = 0
) (
  input  logic [OFF_W-1:0]    off,
  output logic [OUT_FRAC-1:0] y
);
  localparam int IDX_W   = OFF_W - STEP_SH;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int MAXC    = (1 << OUT_FRAC) - 1;

  logic [OUT_FRAC-1:0] rom [0:ENTRIES];

  function automatic logic [OUT_FRAC-1:0] code_at(input int i);
    real x;
    real v;
    int  c;
    x = real'(BASE) + real'(i) * (2.0 ** STEP_SH) / (2.0 ** IN_FRAC);
    v = $tanh(x) * (2.0 ** OUT_FRAC);
    c = $rtoi(v + 0.5);
    if (c > MAXC) c = MAXC;
    return OUT_FRAC'(c);
  endfunction

  initial begin
    for (int i = 0; i <= ENTRIES; i++) rom[i] = code_at(i);
  end

  logic [IDX_W:0] a0;
  assign a0 = {1'b0, off[OFF_W-1:STEP_SH]};

  generate
    if (STEP_SH == 0) begin : g_direct
      assign y = rom[a0];
    end else begin : g_interp
      logic [IDX_W:0]             a1;
      logic [OUT_FRAC-1:0]        y0, y1, diff, step;
      logic [OUT_FRAC+STEP_SH-1:0] prod, rnd;
      assign a1   = a0 + (IDX_W+1)'(1);
      assign y0   = rom[a0];
      assign y1   = rom[a1];
      assign diff = y1 - y0;  // table is monotone, never negative
      assign prod = {{STEP_SH{1'b0}}, diff} * {{OUT_FRAC{1'b0}}, off[STEP_SH-1:0]};
      assign rnd  = prod + (OUT_FRAC+STEP_SH)'(1 << (STEP_SH-1));
      assign step = OUT_FRAC'(rnd >> STEP_SH);
      assign y    = y0 + step;
    end
  endgenerate
endmodule

// File: rtl/tanh_lane.sv
module tanh_lane
  import tanh_pkg::*;
#(
  parameter int LANE_W   = 16,
  parameter int IN_FRAC  = 12,
  parameter int OUT_FRAC = 14,
  parameter int FINE_SH  = 5,
  parameter int COARSE_SH = 6
) (
  input  logic [LANE_W-1:0] x,
  output logic [LANE_W-1:0] y
);
  localparam int MAG_W = LANE_W - 1;

  logic                neg;
  logic [LANE_W-1:0]   full;
  logic [MAG_W-1:0]    mag;
  tanh_band_e          band;
  logic [IN_FRAC-1:0]  fine_off;
  logic [IN_FRAC:0]    coarse_off;
  logic [OUT_FRAC-1:0] fine_y, coarse_y, out_mag;
  logic [LANE_W-1:0]   y_ext;

  assign neg  = x[LANE_W-1];
  assign full = neg ? (~x + LANE_W'(1)) : x;
  // only the most negative code leaves the top bit set after negation
  assign mag  = full[LANE_W-1] ? {MAG_W{1'b1}} : full[MAG_W-1:0];

  tanh_range_dec #(.MAG_W(MAG_W), .IN_FRAC(IN_FRAC)) u_dec (
    .mag(mag), .band(band), .fine_off(fine_off), .coarse_off(coarse_off)
  );

  tanh_segment #(
    .OFF_W(IN_FRAC), .IN_FRAC(IN_FRAC), .OUT_FRAC(OUT_FRAC),
    .STEP_SH(FINE_SH), .BASE(0)
  ) u_fine (.off(fine_off), .y(fine_y));

  tanh_segment #(
    .OFF_W(IN_FRAC+1), .IN_FRAC(IN_FRAC), .OUT_FRAC(OUT_FRAC),
    .STEP_SH(COARSE_SH), .BASE(1)
  ) u_coarse (.off(coarse_off), .y(coarse_y));

  always_comb begin
    unique case (band)
      BAND_FINE:   out_mag = fine_y;
      BAND_COARSE: out_mag = coarse_y;
      default:     out_mag = {OUT_FRAC{1'b1}};
    endcase
  end

  assign y_ext = {{(LANE_W-OUT_FRAC){1'b0}}, out_mag};
  assign y     = neg ? (~y_ext + LANE_W'(1)) : y_ext;
endmodule

// File: rtl/packed_tanh_unit.sv
module packed_tanh_unit
  import tanh_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int WIDE_W    = 16,
  parameter int WIDE_IF   = 12,
  parameter int WIDE_OF   = 14,
  parameter int WIDE_FS   = 5,
  parameter int WIDE_CS   = 6,
  parameter int NARROW_W  = 8,
  parameter int NARROW_IF = 5,
  parameter int NARROW_OF = 6,
  parameter int NARROW_FS = 0,
  parameter int NARROW_CS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              lane_mode,
  input  logic [WORD_W-1:0] operand,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  localparam int N_WIDE   = WORD_W / WIDE_W;
  localparam int N_NARROW = WORD_W / NARROW_W;

  logic [WORD_W-1:0] wide_word, narrow_word;
  logic              accept;

  generate
    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
      tanh_lane #(
        .LANE_W(WIDE_W), .IN_FRAC(WIDE_IF), .OUT_FRAC(WIDE_OF),
        .FINE_SH(WIDE_FS), .COARSE_SH(WIDE_CS)
      ) u_lane (
        .x(operand[g*WIDE_W +: WIDE_W]),
        .y(wide_word[g*WIDE_W +: WIDE_W])
      );
    end
    for (genvar g = 0; g < N_NARROW; g++) begin : g_narrow
      tanh_lane #(
        .LANE_W(NARROW_W), .IN_FRAC(NARROW_IF), .OUT_FRAC(NARROW_OF),
        .FINE_SH(NARROW_FS), .COARSE_SH(NARROW_CS)
      ) u_lane (
        .x(operand[g*NARROW_W +: NARROW_W]),
        .y(narrow_word[g*NARROW_W +: NARROW_W])
      );
    end
  endgenerate

  assign accept = start & ~done;

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= accept;
      if (accept)
        result <= (pack_mode_e'(lane_mode) == PACK_4X8) ? narrow_word : wide_word;
    end
  end
endmodule

// File: rtl/tanh_unit_chk.sv
module tanh_unit_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              lane_mode,
  input logic [WORD_W-1:0] operand,
  input logic              done,
  input logic [WORD_W-1:0] result
);
  // R7
  done_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !done) |=> done);

  // R7
  done_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));

  // R8
  no_back_to_back_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R3
  wide_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(lane_mode) && ($past($signed(operand[15:0])) >= 16'sd12288))
      |-> (result[15:0] == 16'h3FFF));

  // R3
  narrow_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(lane_mode) && ($past($signed(operand[7:0])) >= 8'sd96))
      |-> (result[7:0] == 8'h3F));

  // R5
  wide_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(lane_mode) && !$past(operand[31])) |-> !result[31]);
endmodule

bind packed_tanh_unit tanh_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .lane_mode(lane_mode),
  .operand(operand), .done(done), .result(result)
);

// File: tb/tb_packed_tanh_unit.sv
module tb_packed_tanh_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        mode;
    logic [31:0] op;
    logic        sym;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        lane_mode = 1'b0;
  logic [31:0] operand = '0;
  logic        done;
  logic [31:0] result;

  int    checks = 0;
  int    fails  = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  packed_tanh_unit dut (
    .clk(clk), .rst(rst), .start(start), .lane_mode(lane_mode),
    .operand(operand), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_lane(input int w, input int inf, input int outf,
                            input logic [15:0] xin, input logic [15:0] yin,
                            input string req);
    int  xi, yi, maxc, ei;
    real xr, er, err;
    xi   = (w == 16) ? int'($signed(xin)) : int'($signed(xin[7:0]));
    yi   = (w == 16) ? int'($signed(yin)) : int'($signed(yin[7:0]));
    maxc = (1 << outf) - 1;
    xr   = real'(xi) / (2.0 ** inf);
    if (xr >= 3.0 || xr <= -3.0) begin
      ei = (xi > 0) ? maxc : -maxc;
      if (xi == -(1 << (w-1))) check(yi == ei, "R4", "most negative input", yi, ei);
      else                     check(yi == ei, "R3", "saturation", yi, ei);
    end else begin
      er  = $tanh(xr) * (2.0 ** outf);
      err = real'(yi) - er;
      if (err < 0.0) err = -err;
      check(err <= 2.0, req, $sformatf("tolerance x=%0d", xi), yi, $rtoi(er));
    end
  endtask

  task automatic issue(input logic m, input logic [31:0] op, input logic sym);
    item_t it;
    @(negedge clk);
    lane_mode = m; operand = op; start = 1'b1;
    it.mode = m; it.op = op; it.sym = sym;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7", "done without request", 1, 0);
        end else begin
          it = sb.pop_front();
          if (!it.mode) begin
            for (int k = 0; k < 2; k++)
              check_lane(16, 12, 14, it.op[16*k +: 16], result[16*k +: 16], "R1");
            if (it.sym)
              check(result[31:16] == 16'(-result[15:0]), "R5", "wide negation",
                    result[31:16], 16'(-result[15:0]));
          end else begin
            for (int k = 0; k < 4; k++)
              check_lane(8, 5, 6, {8'h00, it.op[8*k +: 8]}, {8'h00, result[8*k +: 8]},
                         (k < 2) ? "R2" : "R6");
            if (it.sym)
              check(result[15:8] == 8'(-result[7:0]), "R5", "narrow negation",
                    result[15:8], 8'(-result[7:0]));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved;
    @(negedge clk);
    check(done == 1'b0, "R10", "done in reset", done, 0);
    check(result == 32'h0, "R10", "result in reset", result, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R10", "done after reset", done, 0);
    check(result == 32'h0, "R10", "result after reset", result, 0);

    // boundary codes: bands seams, most negative, zero
    issue(1'b0, {16'h8000, 16'h3000}, 1'b0);   // R4, R3
    issue(1'b0, {16'h0FFF, 16'h1000}, 1'b0);   // fine/coarse seam, R1
    issue(1'b0, {16'h2FFF, 16'hD001}, 1'b0);   // coarse top, R1
    issue(1'b1, {8'h80, 8'h60, 8'h1F, 8'h20}, 1'b0);  // R4, R3, seam, R2
    issue(1'b1, {8'hA1, 8'h5F, 8'hE0, 8'h00}, 1'b0);  // R2

    // R8: start held into the done cycle with a new operand
    @(negedge clk);
    lane_mode = 1'b0; operand = {16'h0800, 16'hF800}; start = 1'b1;
    begin
      item_t it;
      it.mode = 1'b0; it.op = {16'h0800, 16'hF800}; it.sym = 1'b1;
      sb.push_back(it);
    end
    @(negedge clk);
    operand = {16'h2000, 16'h1234};
    saved = result;
    @(negedge clk);
    check(done == 1'b0, "R8", "done after ignored start", done, 0);
    check(result == saved, "R8", "result after ignored start", result, saved);
    start = 1'b0;

    // R9: inputs wander with no request
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      lane_mode = c[0]; operand = 32'h1357_9BDF + 32'(c * 7919);
      check(done == 1'b0, "R9", "done idle", done, 0);
      check(result == saved, "R9", "result held", result, saved);
    end

    // full 16-bit sweep with x / -x pairs (R1, R3, R5)
    for (int v = 0; v < 32768; v++)
      issue(1'b0, {16'(-v), 16'(v)}, 1'b1);

    // full 8-bit sweep, lanes 2 and 3 carry unrelated codes (R2, R5, R6)
    for (int v = 0; v < 256; v++)
      issue(1'b1, {8'(v*91 + 200), 8'(v*37 + 11), 8'(-v), 8'(v)}, (v < 128) ? 1'b1 : 1'b0);

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R7", "outstanding requests", sb.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule